// File: doc/BRIEF.md
# SDRAM Bank-State Protocol Monitor

This block sits beside an SDRAM command bus and only listens to it. On every rising clock edge it turns chip select and the three active-low strobes into a command. It then keeps, for each of four banks, whether a row is open and which row it is. The command is checked against the spacing and state rules of the protocol. Every rule has a cycle limit set by a parameter. The defaults assume a 5 ns clock: 20 ns becomes 4 cycles, 42 ns becomes 9, 70 ns becomes 14 and 100 µs becomes 20000.

Each violation class has its own code. The code of the highest-priority violation seen on an edge appears on `err_code` for the following cycle, and the same event sets a bit in a sticky vector that only reset clears. The monitor never drives the bus and has no flow control. It takes one command per cycle and never stalls, so there is no back-pressure to manage. A read or write with the auto-precharge address bit set closes its bank a fixed number of cycles later without any precharge command on the bus.

Top module: `sdram_bank_monitor`

## Requirements
- R1: When `cs_n` is high the cycle is a no-op, whatever the strobes carry. When `cs_n` is low, `{ras_n,cas_n,we_n}` decodes as activate 011, read 101, write 100, precharge 010, refresh 001, mode set 000, burst stop 110 and no-op 111.
- R2: An activate opens the addressed bank and stores `addr` as its row, visible on `bank_active[b]` and `open_rows[b*ROW_W +: ROW_W]` after that edge. A precharge closes the addressed bank, or every bank when `addr[AP_BIT]` is 1.
- R3: An activate to a bank that is already open reports code 1.
- R4: An activate to a bank other than the previous activate's bank, fewer than `T_RRD` cycles after that activate, reports code 2. A gap of exactly `T_RRD` is legal.
- R5: A read or write to a closed bank reports code 3. A read or write to an open bank fewer than `T_RCD` cycles after its activate reports code 4.
- R6: A precharge that closes an open bank fewer than `T_RAS_MIN` cycles after its activate reports code 5. A precharge aimed at a closed bank is legal.
- R7: A bank left open with no precharge and no auto-precharge pending reports code 6 exactly once, on the edge `T_RAS_MAX` cycles after its activate. A precharge on that edge is legal.
- R8: A refresh while any bank is open reports code 7.
- R9: Any command other than a no-op fewer than `T_RFC` cycles after a refresh reports code 8.
- R10: Any command other than a no-op fewer than `T_MRD` cycles after a mode set reports code 9.
- R11: A read or write to an open bank with `addr[AP_BIT]` = 1 closes that bank on the edge `AP_CYCLES` cycles later. Without that bit the bank stays open.
- R12: `err_code` is registered: it shows, for one cycle, the lowest-numbered code raised on the previous edge, or 0 if none was raised. Code k also sets `err_sticky[k-1]`, and that bit stays set until reset.
- R13: Reset leaves all banks closed, `err_code` at 0 and `err_sticky` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank | input | BANK_W (2) | Bank address |
| addr | input | ROW_W (12) | Row address, or column address with the auto-precharge / all-banks bit at AP_BIT |
| bank_active | output | NUM_BANKS (4) | One bit per bank, set while a row is open |
| open_rows | output | NUM_BANKS*ROW_W (48) | Row of each bank, packed with bank 0 in the low bits |
| err_code | output | 4 | Code of the previous edge's highest-priority violation, 0 if none |
| err_sticky | output | 9 | Bit k-1 set once code k has been seen |

## Verification
Each spacing rule is swept over every gap from one cycle up to a little past its limit. This separates the last illegal gap from the first legal one and catches off-by-one counters. The activate sweeps switch bank, so per-bank age is kept apart from the global activate-to-activate window. The row-open limit is checked at its exact edge both with and without a precharge on that edge. Auto-precharge is checked against a plain read, so closing a bank on its own is kept apart from leaving it open. A cycle that breaks two rules at once shows which code wins.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE,
    CMD_REF,
    CMD_MRS,
    CMD_BST
  } cmd_e;

  localparam int NUM_ERR = 9;

  // Lower code = higher priority on err_code.
  localparam logic [3:0] E_NONE     = 4'd0;
  localparam logic [3:0] E_DBL_ACT  = 4'd1;
  localparam logic [3:0] E_RRD      = 4'd2;
  localparam logic [3:0] E_RW_IDLE  = 4'd3;
  localparam logic [3:0] E_RCD      = 4'd4;
  localparam logic [3:0] E_RAS_MIN  = 4'd5;
  localparam logic [3:0] E_RAS_MAX  = 4'd6;
  localparam logic [3:0] E_REF_OPEN = 4'd7;
  localparam logic [3:0] E_RFC      = 4'd8;
  localparam logic [3:0] E_MRD      = 4'd9;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  // R1: strobe decode, chip select gates everything.
  always_comb begin
    if (cs_n) begin
      cmd = CMD_NOP;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = CMD_MRS;
        3'b110:  cmd = CMD_BST;
        default: cmd = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdram_gap_counter.sv
module sdram_gap_counter #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic too_close
);

  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] SAT = CW'(LIMIT);

  // Cycles since the last restart, saturating at LIMIT.
  logic [CW-1:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap <= SAT;
    end else if (restart) begin
      gap <= CW'(1);
    end else if (gap != SAT) begin
      gap <= gap + CW'(1);
    end
  end

  assign too_close = (gap < SAT);

  generate
    if (LIMIT > 1) begin : g_chk
      // Shared by the R4, R9 and R10 windows.
      p_window_after_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> too_close);
    end
  endgenerate

endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track #(
  parameter int ROW_W     = 12,
  parameter int T_RCD     = 4,
  parameter int T_RAS_MIN = 9,
  parameter int T_RAS_MAX = 20000,
  parameter int AP_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_hit,
  input  logic             rw_hit,
  input  logic             rw_auto,
  input  logic             pre_hit,
  input  logic [ROW_W-1:0] row_in,
  output logic             active,
  output logic [ROW_W-1:0] open_row,
  output logic             err_dbl_act,
  output logic             err_rw_idle,
  output logic             err_rcd,
  output logic             err_ras_min,
  output logic             err_ras_max
);

  localparam int CW = $clog2(T_RAS_MAX + 2);
  localparam int AW = (AP_CYCLES < 2) ? 1 : $clog2(AP_CYCLES + 1);
  localparam logic [CW-1:0] AGE_SAT = CW'(T_RAS_MAX + 1);

  logic [CW-1:0] age;
  logic [AW-1:0] ap_left;
  logic          ap_pend;

  assign ap_pend = (ap_left != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      open_row <= '0;
      age      <= AGE_SAT;
      ap_left  <= '0;
    end else if (act_hit) begin
      active   <= 1'b1;
      open_row <= row_in;
      age      <= CW'(1);
      ap_left  <= '0;
    end else begin
      if (age != AGE_SAT) age <= age + CW'(1);
      if (pre_hit) begin
        active  <= 1'b0;
        ap_left <= '0;
      end else if (ap_left == AW'(1)) begin
        active  <= 1'b0;
        ap_left <= '0;
      end else if (ap_pend) begin
        ap_left <= ap_left - AW'(1);
      end else if (rw_hit && rw_auto && active) begin
        ap_left <= AW'(AP_CYCLES);
      end
    end
  end

  assign err_dbl_act = act_hit && active;
  assign err_rw_idle = rw_hit && !active;
  assign err_rcd     = rw_hit && active && (age < CW'(T_RCD));
  assign err_ras_min = pre_hit && active && (age < CW'(T_RAS_MIN));
  assign err_ras_max = active && !ap_pend && !pre_hit && (age == CW'(T_RAS_MAX));

  p_act_opens_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
    act_hit |=> (active && open_row == $past(row_in)));

  p_pre_closes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_hit && !act_hit) |=> !active);

  p_auto_close_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_left == AW'(1) && !act_hit) |=> !active);

  p_ras_max_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_ras_max |=> !err_ras_max);

endmodule

// File: rtl/sdram_bank_monitor.sv
module sdram_bank_monitor
  import sdram_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int AP_BIT    = 10,
  parameter int T_RRD     = 4,
  parameter int T_RCD     = 4,
  parameter int T_RAS_MIN = 9,
  parameter int T_RAS_MAX = 20000,
  parameter int T_RFC     = 14,
  parameter int T_MRD     = 2,
  parameter int AP_CYCLES = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_n,
  input  logic                       ras_n,
  input  logic                       cas_n,
  input  logic                       we_n,
  input  logic [BANK_W-1:0]          bank,
  input  logic [ROW_W-1:0]           addr,
  output logic [NUM_BANKS-1:0]       bank_active,
  output logic [NUM_BANKS*ROW_W-1:0] open_rows,
  output logic [3:0]                 err_code,
  output logic [NUM_ERR-1:0]         err_sticky
);

  cmd_e cmd;
  logic cmd_real;
  logic rrd_close, rfc_close, mrd_close;
  logic [BANK_W-1:0] last_act_bank;

  logic [NUM_BANKS-1:0] dbl_v, idle_v, rcd_v, rmin_v, rmax_v;
  logic [NUM_ERR-1:0]   ev;
  logic [3:0]           code_nxt;

  sdram_cmd_decode u_dec (
    .cs_n (cs_n),
    .ras_n(ras_n),
    .cas_n(cas_n),
    .we_n (we_n),
    .cmd  (cmd)
  );

  assign cmd_real = (cmd != CMD_NOP);

  sdram_gap_counter #(.LIMIT(T_RRD)) u_rrd (
    .clk(clk), .rst_n(rst_n), .restart(cmd == CMD_ACT), .too_close(rrd_close));

  sdram_gap_counter #(.LIMIT(T_RFC)) u_rfc (
    .clk(clk), .rst_n(rst_n), .restart(cmd == CMD_REF), .too_close(rfc_close));

  sdram_gap_counter #(.LIMIT(T_MRD)) u_mrd (
    .clk(clk), .rst_n(rst_n), .restart(cmd == CMD_MRS), .too_close(mrd_close));

  generate
    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
      logic sel;
      assign sel = (bank == BANK_W'(i));

      sdram_bank_track #(
        .ROW_W    (ROW_W),
        .T_RCD    (T_RCD),
        .T_RAS_MIN(T_RAS_MIN),
        .T_RAS_MAX(T_RAS_MAX),
        .AP_CYCLES(AP_CYCLES)
      ) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_hit    ((cmd == CMD_ACT) && sel),
        .rw_hit     ((cmd == CMD_RD || cmd == CMD_WR) && sel),
        .rw_auto    (addr[AP_BIT]),
        .pre_hit    ((cmd == CMD_PRE) && (sel || addr[AP_BIT])),
        .row_in     (addr),
        .active     (bank_active[i]),
        .open_row   (open_rows[i*ROW_W +: ROW_W]),
        .err_dbl_act(dbl_v[i]),
        .err_rw_idle(idle_v[i]),
        .err_rcd    (rcd_v[i]),
        .err_ras_min(rmin_v[i]),
        .err_ras_max(rmax_v[i])
      );
    end
  endgenerate

  // One event bit per error class; bit k-1 carries code k.
  always_comb begin
    ev = '0;
    ev[int'(E_DBL_ACT)  - 1] = |dbl_v;
    ev[int'(E_RRD)      - 1] = (cmd == CMD_ACT) && rrd_close && (bank != last_act_bank);
    ev[int'(E_RW_IDLE)  - 1] = |idle_v;
    ev[int'(E_RCD)      - 1] = |rcd_v;
    ev[int'(E_RAS_MIN)  - 1] = |rmin_v;
    ev[int'(E_RAS_MAX)  - 1] = |rmax_v;
    ev[int'(E_REF_OPEN) - 1] = (cmd == CMD_REF) && (|bank_active);
    ev[int'(E_RFC)      - 1] = cmd_real && rfc_close;
    ev[int'(E_MRD)      - 1] = cmd_real && mrd_close;
  end

  // Lowest code wins.
  always_comb begin
    code_nxt = E_NONE;
    for (int k = NUM_ERR - 1; k >= 0; k--) begin
      if (ev[k]) code_nxt = 4'(k + 1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_code      <= E_NONE;
      err_sticky    <= '0;
      last_act_bank <= '0;
    end else begin
      err_code   <= code_nxt;
      err_sticky <= err_sticky | ev;
      if (cmd == CMD_ACT) last_act_bank <= bank;
    end
  end

  p_sticky_keeps_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sticky != '0) |=> ((err_sticky & $past(err_sticky)) == $past(err_sticky)));

  p_code_in_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != E_NONE) |-> err_sticky[err_code - 4'd1]);

  p_ref_open_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == CMD_REF) && (bank_active != '0)) |=> (err_code != E_NONE));

endmodule

// File: tb/sdram_bank_monitor_tb.sv
`timescale 1ns/1ps
module sdram_bank_monitor_tb;

  localparam int RAS_MAX = 50;
  localparam int RRD = 4, RCD = 4, RAS_MIN = 9, RFC = 14, MRD = 2, APC = 4;

  localparam logic [2:0] C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100,
                         C_PRE = 3'b010, C_REF = 3'b001, C_MRS = 3'b000,
                         C_BST = 3'b110, C_NOP = 3'b111;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic        cs_n, ras_n, cas_n, we_n;
  logic [1:0]  bank;
  logic [11:0] addr;
  logic [3:0]  bank_active;
  logic [47:0] open_rows;
  logic [3:0]  err_code;
  logic [8:0]  err_sticky;

  sdram_bank_monitor #(.T_RAS_MAX(RAS_MAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .bank(bank), .addr(addr), .bank_active(bank_active),
    .open_rows(open_rows), .err_code(err_code), .err_sticky(err_sticky));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic issue(input logic csn, input logic [2:0] rcw,
                       input logic [1:0] b, input logic [11:0] a);
    cs_n = csn; {ras_n, cas_n, we_n} = rcw; bank = b; addr = a;
    @(posedge clk);
    @(negedge clk);
    cs_n = 1'b1; {ras_n, cas_n, we_n} = C_NOP; bank = '0; addr = '0;
  endtask

  task automatic nop(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic close_all();
    nop(14);
    issue(1'b0, C_PRE, 2'd0, 12'h400);
    nop(15);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R13 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; {ras_n, cas_n, we_n} = C_NOP; bank = '0; addr = '0;
    repeat (3) @(negedge clk);
    chk("R13 reset err_code", err_code, 0);
    chk("R13 reset sticky", err_sticky, 0);
    chk("R13 reset banks", bank_active, 0);
    rst_n = 1'b1;
    nop(2);

    // R1: deselected activate / refresh patterns do nothing
    issue(1'b1, C_ACT, 2'd0, 12'h123);
    chk("R1 cs_n high act ignored", bank_active, 0);
    issue(1'b1, C_REF, 2'd0, 12'h0);
    nop(1);
    chk("R1 cs_n high no error", err_sticky, 0);

    // R2: open all banks, then close one and then all
    for (int i = 0; i < 4; i++) begin
      issue(1'b0, C_ACT, 2'(i), 12'h100 + 12'(i));
      chk("R2 act opens", bank_active[i], 1);
      chk("R2 row stored", open_rows[i*12 +: 12], 'h100 + i);
      chk("R2 legal act", err_code, 0);
      if (i < 3) nop(3);
    end
    nop(10);
    issue(1'b0, C_PRE, 2'd1, 12'h000);
    chk("R2 single precharge", bank_active, 4'b1101);
    issue(1'b0, C_PRE, 2'd0, 12'h400);
    chk("R2 precharge all", bank_active, 0);
    chk("R2 no error", err_sticky, 0);
    nop(4);

    // R3: double activate
    issue(1'b0, C_ACT, 2'd2, 12'h010);
    nop(5);
    issue(1'b0, C_ACT, 2'd2, 12'h020);
    chk("R3 double activate", err_code, 1);
    chk("R12 first sticky bit", err_sticky, 9'h001);
    nop(1);
    chk("R12 code lasts one cycle", err_code, 0);
    chk("R3 row replaced", open_rows[2*12 +: 12], 'h020);
    close_all();

    // R4: activate-to-activate spacing across banks
    for (int g = 1; g <= 6; g++) begin
      issue(1'b0, C_ACT, 2'd0, 12'h001);
      nop(g - 1);
      issue(1'b0, C_ACT, 2'd3, 12'h002);
      chk($sformatf("R4 rrd gap %0d", g), err_code, (g < RRD) ? 2 : 0);
      close_all();
    end

    // R5: access to idle bank, and activate-to-access spacing
    issue(1'b0, C_RD, 2'd1, 12'h000);
    chk("R5 read idle bank", err_code, 3);
    issue(1'b0, C_WR, 2'd2, 12'h000);
    chk("R5 write idle bank", err_code, 3);
    nop(2);
    for (int g = 1; g <= 6; g++) begin
      issue(1'b0, C_ACT, 2'd1, 12'h055);
      nop(g - 1);
      issue(1'b0, (g % 2 == 0) ? C_WR : C_RD, 2'd1, 12'h000);
      chk($sformatf("R5 rcd gap %0d", g), err_code, (g < RCD) ? 4 : 0);
      close_all();
    end

    // R6: minimum row-open time
    for (int g = 1; g <= 11; g++) begin
      issue(1'b0, C_ACT, 2'd2, 12'h066);
      nop(g - 1);
      issue(1'b0, C_PRE, 2'd2, 12'h000);
      chk($sformatf("R6 ras min gap %0d", g), err_code, (g < RAS_MIN) ? 5 : 0);
      nop(4);
    end
    issue(1'b0, C_PRE, 2'd3, 12'h000);
    chk("R6 precharge idle bank", err_code, 0);
    nop(4);

    // R7: maximum row-open time
    issue(1'b0, C_ACT, 2'd1, 12'h077);
    nop(RAS_MAX - 1);
    issue(1'b0, C_PRE, 2'd1, 12'h000);
    chk("R7 precharge at limit", err_code, 0);
    nop(2);
    chk("R7 no late flag", err_code, 0);
    issue(1'b0, C_ACT, 2'd0, 12'h088);
    nop(RAS_MAX - 1);
    chk("R7 before limit", err_code, 0);
    nop(1);
    chk("R7 at limit", err_code, 6);
    nop(1);
    chk("R7 reported once", err_code, 0);
    close_all();

    // R8: refresh with an open bank
    issue(1'b0, C_ACT, 2'd3, 12'h099);
    nop(10);
    issue(1'b0, C_REF, 2'd0, 12'h000);
    chk("R8 refresh open bank", err_code, 7);
    close_all();
    issue(1'b0, C_REF, 2'd0, 12'h000);
    chk("R8 refresh all idle", err_code, 0);
    nop(RFC);

    // R9: refresh recovery
    for (int g = 1; g <= 16; g++) begin
      issue(1'b0, C_REF, 2'd0, 12'h000);
      nop(g - 1);
      issue(1'b0, C_BST, 2'd0, 12'h000);
      chk($sformatf("R9 rfc gap %0d", g), err_code, (g < RFC) ? 8 : 0);
      nop(RFC);
    end

    // R10: mode-set spacing
    for (int g = 1; g <= 3; g++) begin
      issue(1'b0, C_MRS, 2'd0, 12'h032);
      nop(g - 1);
      issue(1'b0, C_BST, 2'd0, 12'h000);
      chk($sformatf("R10 mrd gap %0d", g), err_code, (g < MRD) ? 9 : 0);
      nop(3);
    end

    // R11: auto-precharge closes the bank; a plain read does not
    issue(1'b0, C_ACT, 2'd1, 12'h0AA);
    nop(3);
    issue(1'b0, C_RD, 2'd1, 12'h400);
    chk("R11 read ap legal", err_code, 0);
    nop(APC - 1);
    chk("R11 open before close", bank_active[1], 1);
    nop(1);
    chk("R11 closed after read", bank_active[1], 0);
    issue(1'b0, C_ACT, 2'd2, 12'h0BB);
    nop(3);
    issue(1'b0, C_WR, 2'd2, 12'h400);
    nop(APC);
    chk("R11 closed after write", bank_active[2], 0);
    issue(1'b0, C_RD, 2'd2, 12'h000);
    chk("R11 access after close", err_code, 3);
    issue(1'b0, C_ACT, 2'd3, 12'h0CC);
    nop(3);
    issue(1'b0, C_RD, 2'd3, 12'h000);
    nop(APC + 2);
    chk("R11 plain read keeps open", bank_active[3], 1);
    close_all();

    // R12: two rules broken on one edge, lowest code wins
    issue(1'b0, C_ACT, 2'd0, 12'h0DD);
    nop(10);
    issue(1'b0, C_MRS, 2'd0, 12'h032);
    issue(1'b0, C_REF, 2'd0, 12'h000);
    chk("R12 priority ref-open over mrd", err_code, 7);
    close_all();
    chk("R12 all classes sticky", err_sticky, 9'h1FF);

    // R13: reset clears the sticky vector and closes banks
    issue(1'b0, C_ACT, 2'd1, 12'h0EE);
    rst_n = 1'b0;
    nop(2);
    chk("R13 sticky cleared", err_sticky, 0);
    chk("R13 banks closed", bank_active, 0);
    rst_n = 1'b1;
    nop(2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule